// File: doc/BRIEF.md
# Vector-Length Sequential Line Prefetcher

This controller sits beside a direct-mapped data cache (64-byte lines, 16 KB by default) and turns each cache miss into a sequence of line-fill requests to external memory. The missing line is always fetched first. After it, the controller may fetch further lines in ascending address order, and two trigger policies decide how many. In the fixed policy every miss is followed by a programmed count of lines. In the vector policy only misses raised by unit-stride vector memory instructions trigger prefetching. The number of lines is then a programmable multiple of the vector length times the 4-byte element size, rounded up to whole lines and capped at the counter limit. With this sizing, a vector memory instruction normally sees at most one miss.

Before each prefetch, the controller probes the cache's tag array. Lines already resident are skipped at the cost of one cycle and use no memory time. A prefetch that would evict a dirty line is refused when the writeback buffer is disabled or full. When the buffer is enabled and has room, the victim's line address is queued and the prefetch goes ahead. Queued victims are written back, oldest first, whenever no demand or prefetch work is waiting. A burst stops at the edge of the 4 KB region that holds the demand line. External memory is modelled as a port held busy for a fixed 9 cycles per line transfer.

Top module: `vl_prefetch_ctrl`

## Requirements
- R1: After reset, neither `mem_req_valid` nor `probe_valid` is asserted until a miss arrives.
- R2: A miss seen while the controller is idle produces a demand request (`mem_req_kind` 0) for `miss_line` on the clock edge that samples the miss.
- R3: With `cfg_vl_mode`=0, every miss is followed by prefetch requests (`mem_req_kind` 1) for the next `cfg_fixed_k` lines, in ascending order.
- R4: With `cfg_vl_mode`=1, a miss with `miss_seq_vec`=0 produces only its demand request.
- R5: With `cfg_vl_mode`=1 and `miss_seq_vec`=1, the prefetch count is ceil(`cfg_vl_mult`*`vec_len`*4/64), saturating at 2^CNT_W-1 (15 by default).
- R6: Each request holds the memory port for LATENCY (9) cycles. The next chosen action is taken on the 9th edge after a request. A prefetch needs one extra probe cycle, so a prefetch that follows another request comes 10 cycles after it.
- R7: A probed line reported present (`probe_hit`=1) issues no memory request, and the next line is probed one cycle later.
- R8: Prefetching stops before the first line whose address bits above bit 5 of the line index (the 4 KB region) differ from those of the demand line.
- R9: With `cfg_wb_en`=0, a prefetch whose victim is dirty (`probe_dirty`=1) is skipped, and its victim is not written back.
- R10: With `cfg_wb_en`=1 and buffer space, a dirty victim's `probe_victim` line is queued and the prefetch is issued. Queued victims leave as writeback requests (`mem_req_kind` 2), oldest first, only when no demand or prefetch is pending.
- R11: When the WB_DEPTH-entry buffer (2 by default) is full, a prefetch with a dirty victim is skipped.
- R12: A miss arriving during a burst is issued as a demand on the edge where the current fill ends. The older burst's remaining prefetches are dropped, and the new miss starts its own burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | One-cycle pulse: the cache missed |
| miss_line | input | ADDR_W-LINE_LG2 | Line address of the miss |
| miss_seq_vec | input | 1 | Miss came from a unit-stride vector access |
| vec_len | input | VL_W | Current vector length in elements |
| cfg_vl_mode | input | 1 | 0: fixed count on any miss; 1: vector-length policy |
| cfg_fixed_k | input | CNT_W | Line count for the fixed policy |
| cfg_vl_mult | input | MULT_W | Multiple of the vector length for the vector policy |
| cfg_wb_en | input | 1 | Allow dirty victims into the writeback buffer |
| probe_valid | output | 1 | Tag probe request for `probe_line` |
| probe_line | output | ADDR_W-LINE_LG2 | Line being probed |
| probe_hit | input | 1 | Probed line is resident (valid in the cycle after `probe_valid`) |
| probe_dirty | input | 1 | Line the prefetch would evict is dirty (same timing) |
| probe_victim | input | ADDR_W-LINE_LG2 | Line address of that victim (same timing) |
| mem_req_valid | output | 1 | Line transfer request to memory |
| mem_req_kind | output | 2 | 0 demand, 1 prefetch, 2 writeback |
| mem_req_line | output | ADDR_W-LINE_LG2 | Line address of the transfer |

## Verification
Every result is tied to one edge. A demand issued from idle appears on the edge that samples the miss. The next action is taken on the 9th edge after any request. A prefetch appears one probe cycle later, so 10 edges after the previous request, and a resident or refused line adds exactly one edge. The driver computes the cycle number of each expected request from these rules and queues it with its kind and line. The monitor compares the queued cycle, kind and line against the outputs at each falling edge, so an early, late, missing or extra request all count as failures.

// File: rtl/vlpf_pkg.sv
package vlpf_pkg;
  typedef enum logic [1:0] {
    REQ_DEMAND    = 2'd0,
    REQ_PREFETCH  = 2'd1,
    REQ_WRITEBACK = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_PROBE = 2'd2
  } pf_state_e;
endpackage

// File: rtl/vlpf_depth.sv
module vlpf_depth #(
  parameter int VL_W     = 7,
  parameter int MULT_W   = 4,
  parameter int CNT_W    = 4,
  parameter int ELEM_LG2 = 2,
  parameter int LINE_LG2 = 6
) (
  input  logic              vl_mode,
  input  logic              seq_vec,
  input  logic [CNT_W-1:0]  fixed_k,
  input  logic [MULT_W-1:0] mult,
  input  logic [VL_W-1:0]   vl,
  output logic [CNT_W-1:0]  count
);
  localparam int PW     = VL_W + MULT_W + ELEM_LG2 + 1;
  localparam int PF_MAX = (1 << CNT_W) - 1;

  logic [PW-1:0]    span_bytes;
  logic [PW-1:0]    span_lines;
  logic [CNT_W-1:0] vl_count;

  // bytes touched by mult*vl elements, rounded up to whole lines
  assign span_bytes = (PW'(mult) * PW'(vl)) << ELEM_LG2;
  assign span_lines = (span_bytes + PW'((1 << LINE_LG2) - 1)) >> LINE_LG2;
  assign vl_count   = (span_lines > PW'(PF_MAX)) ? CNT_W'(PF_MAX)
                                                 : span_lines[CNT_W-1:0];
  assign count      = vl_mode ? (seq_vec ? vl_count : '0) : fixed_k;
endmodule

// File: rtl/vlpf_wbuf.sv
module vlpf_wbuf #(
  parameter int DEPTH = 2,
  parameter int W     = 26
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_line,
  input  logic         pop,
  output logic [W-1:0] head_line,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] fill;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      fill <= fill + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head_line = store[rd_ptr];
  assign empty     = (fill == '0);
  assign full      = (fill == CNT_W'(DEPTH));

  AST_WB_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> !full); // R11
  AST_WB_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty); // R10
endmodule

// File: rtl/vl_prefetch_ctrl.sv
module vl_prefetch_ctrl
  import vlpf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_LG2   = 6,
  parameter int REGION_LG2 = 12,
  parameter int LATENCY    = 9,
  parameter int CNT_W      = 4,
  parameter int VL_W       = 7,
  parameter int MULT_W     = 4,
  parameter int ELEM_LG2   = 2,
  parameter int WB_DEPTH   = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         miss_valid,
  input  logic [ADDR_W-LINE_LG2-1:0]   miss_line,
  input  logic                         miss_seq_vec,
  input  logic [VL_W-1:0]              vec_len,
  input  logic                         cfg_vl_mode,
  input  logic [CNT_W-1:0]             cfg_fixed_k,
  input  logic [MULT_W-1:0]            cfg_vl_mult,
  input  logic                         cfg_wb_en,
  output logic                         probe_valid,
  output logic [ADDR_W-LINE_LG2-1:0]   probe_line,
  input  logic                         probe_hit,
  input  logic                         probe_dirty,
  input  logic [ADDR_W-LINE_LG2-1:0]   probe_victim,
  output logic                         mem_req_valid,
  output logic [1:0]                   mem_req_kind,
  output logic [ADDR_W-LINE_LG2-1:0]   mem_req_line
);
  localparam int LW    = ADDR_W - LINE_LG2;
  localparam int RB    = REGION_LG2 - LINE_LG2;
  localparam int LAT_W = $clog2(LATENCY + 1);
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(LATENCY - 1);

  pf_state_e        state;
  logic [LAT_W-1:0] lat_cnt;
  logic             pend_v, pend_seq;
  logic [LW-1:0]    pend_line;
  logic [CNT_W-1:0] pf_left;
  logic [LW-1:0]    cur_line, base_line;
  logic             wb_en_r;

  logic             dem_v, dem_seq;
  logic [LW-1:0]    dem_line, next_line;
  logic [CNT_W-1:0] depth_cnt;
  logic             in_region, more_pf, pf_ok, choose, take_dem;
  logic             wb_push, wb_pop, wb_empty, wb_full;
  logic [LW-1:0]    wb_head;

  // a waiting demand takes precedence over a miss in the same cycle
  assign dem_v     = pend_v | miss_valid;
  assign dem_line  = pend_v ? pend_line : miss_line;
  assign dem_seq   = pend_v ? pend_seq  : miss_seq_vec;
  assign next_line = cur_line + 1'b1;
  assign in_region = (next_line[LW-1:RB] == base_line[LW-1:RB]);
  assign more_pf   = (pf_left != '0) && in_region;

  assign pf_ok    = (state == ST_PROBE) && !dem_v && !probe_hit &&
                    (!probe_dirty || (wb_en_r && !wb_full));
  assign choose   = (state == ST_IDLE) ||
                    ((state == ST_FILL) && (lat_cnt == '0)) ||
                    ((state == ST_PROBE) && !pf_ok);
  assign take_dem = choose && dem_v;
  assign wb_push  = pf_ok && probe_dirty;
  assign wb_pop   = choose && !dem_v && !more_pf && !wb_empty;

  vlpf_depth #(
    .VL_W(VL_W), .MULT_W(MULT_W), .CNT_W(CNT_W),
    .ELEM_LG2(ELEM_LG2), .LINE_LG2(LINE_LG2)
  ) depth_i (
    .vl_mode(cfg_vl_mode), .seq_vec(dem_seq), .fixed_k(cfg_fixed_k),
    .mult(cfg_vl_mult), .vl(vec_len), .count(depth_cnt)
  );

  vlpf_wbuf #(.DEPTH(WB_DEPTH), .W(LW)) wbuf_i (
    .clk(clk), .rst(rst), .push(wb_push), .push_line(probe_victim),
    .pop(wb_pop), .head_line(wb_head), .empty(wb_empty), .full(wb_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      lat_cnt       <= '0;
      pend_v        <= 1'b0;
      pend_seq      <= 1'b0;
      pend_line     <= '0;
      pf_left       <= '0;
      cur_line      <= '0;
      base_line     <= '0;
      wb_en_r       <= 1'b0;
      probe_valid   <= 1'b0;
      probe_line    <= '0;
      mem_req_valid <= 1'b0;
      mem_req_kind  <= REQ_DEMAND;
      mem_req_line  <= '0;
    end else begin
      mem_req_valid <= 1'b0;
      probe_valid   <= 1'b0;
      if (take_dem) begin
        pend_v <= 1'b0;
      end else if (miss_valid) begin
        pend_v    <= 1'b1;
        pend_line <= miss_line;
        pend_seq  <= miss_seq_vec;
      end
      if ((state == ST_FILL) && (lat_cnt != '0)) lat_cnt <= lat_cnt - 1'b1;
      if (pf_ok) begin
        mem_req_valid <= 1'b1;
        mem_req_kind  <= REQ_PREFETCH;
        mem_req_line  <= cur_line;
        lat_cnt       <= LAT_LAST;
        state         <= ST_FILL;
      end
      if (choose) begin
        if (dem_v) begin
          mem_req_valid <= 1'b1;
          mem_req_kind  <= REQ_DEMAND;
          mem_req_line  <= dem_line;
          base_line     <= dem_line;
          cur_line      <= dem_line;
          pf_left       <= depth_cnt;
          wb_en_r       <= cfg_wb_en;
          lat_cnt       <= LAT_LAST;
          state         <= ST_FILL;
        end else if (more_pf) begin
          probe_valid   <= 1'b1;
          probe_line    <= next_line;
          cur_line      <= next_line;
          pf_left       <= pf_left - 1'b1;
          state         <= ST_PROBE;
        end else if (!wb_empty) begin
          mem_req_valid <= 1'b1;
          mem_req_kind  <= REQ_WRITEBACK;
          mem_req_line  <= wb_head;
          pf_left       <= '0;
          lat_cnt       <= LAT_LAST;
          state         <= ST_FILL;
        end else begin
          pf_left       <= '0;
          state         <= ST_IDLE;
        end
      end
    end
  end

  // checker state, kept apart from the control path
  logic [LAT_W-1:0] chk_gap;
  logic [LW-1:0]    chk_last;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_gap  <= LAT_W'(LATENCY);
      chk_last <= '0;
    end else begin
      if (mem_req_valid) chk_gap <= LAT_W'(1);
      else if (chk_gap < LAT_W'(LATENCY)) chk_gap <= chk_gap + 1'b1;
      if (mem_req_valid && (mem_req_kind != REQ_WRITEBACK)) chk_last <= mem_req_line;
    end
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_req_valid && !probe_valid)); // R1
  AST_PORT_SPACING: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (chk_gap >= LAT_W'(LATENCY))); // R6
  AST_PF_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && (mem_req_kind == REQ_PREFETCH)) |->
      ((mem_req_line > chk_last) && (mem_req_line[LW-1:RB] == chk_last[LW-1:RB]))); // R8
  AST_PROBE_OR_REQ: assert property (@(posedge clk) disable iff (rst)
    $onehot0({probe_valid, mem_req_valid})); // R7
endmodule

// File: tb/vl_prefetch_ctrl_tb.sv
module vl_prefetch_ctrl_tb_top;
  localparam int LW = 26;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          miss_valid = 1'b0;
  logic [LW-1:0] miss_line = '0;
  logic          miss_seq_vec = 1'b0;
  logic [6:0]    vec_len = '0;
  logic          cfg_vl_mode = 1'b0;
  logic [3:0]    cfg_fixed_k = '0;
  logic [3:0]    cfg_vl_mult = '0;
  logic          cfg_wb_en = 1'b0;
  logic          probe_valid;
  logic [LW-1:0] probe_line;
  logic          probe_hit = 1'b0;
  logic          probe_dirty = 1'b0;
  logic [LW-1:0] probe_victim = '0;
  logic          mem_req_valid;
  logic [1:0]    mem_req_kind;
  logic [LW-1:0] mem_req_line;

  vl_prefetch_ctrl dut_i (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_line(miss_line),
    .miss_seq_vec(miss_seq_vec), .vec_len(vec_len), .cfg_vl_mode(cfg_vl_mode),
    .cfg_fixed_k(cfg_fixed_k), .cfg_vl_mult(cfg_vl_mult), .cfg_wb_en(cfg_wb_en),
    .probe_valid(probe_valid), .probe_line(probe_line), .probe_hit(probe_hit),
    .probe_dirty(probe_dirty), .probe_victim(probe_victim),
    .mem_req_valid(mem_req_valid), .mem_req_kind(mem_req_kind),
    .mem_req_line(mem_req_line)
  );

  always #4 clk = ~clk; // 125 MHz

  typedef struct {
    int    cyc;
    int    kind;
    int    line;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0;
  int    n_checks = 0;
  int    n_fail = 0;
  string cur_tag = "R1";
  bit    hit_m[int];
  bit    dirty_m[int];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // cache tag model: answers a probe in the following cycle;
  // the victim shares the index of a 16 KB direct-mapped cache
  always @(negedge clk) begin
    if (probe_valid) begin
      probe_hit    <= hit_m.exists(int'(probe_line));
      probe_dirty  <= dirty_m.exists(int'(probe_line));
      probe_victim <= probe_line + 26'h100;
    end else begin
      probe_hit    <= 1'b0;
      probe_dirty  <= 1'b0;
    end
  end

  // monitor: pops and compares each memory request
  always @(negedge clk) begin
    if (!rst && mem_req_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, cur_tag, "unexpected request line", int'(mem_req_line), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.cyc, e.tag, "request cycle", cyc, e.cyc);
        chk(int'(mem_req_kind) == e.kind, e.tag, "request kind", int'(mem_req_kind), e.kind);
        chk(int'(mem_req_line) == e.line, e.tag, "request line", int'(mem_req_line), e.line);
      end
    end
  end

  task automatic expect_req(input int c, input int k, input int l, input string tag);
    exp_t e;
    e.cyc = c; e.kind = k; e.line = l; e.tag = tag;
    q.push_back(e);
  endtask

  // drives a one-cycle miss; returns the cycle of the sampling edge
  task automatic drive_miss(input int line, input bit seq, output int edge_cyc);
    @(negedge clk);
    miss_valid   = 1'b1;
    miss_line    = LW'(line);
    miss_seq_vec = seq;
    edge_cyc     = cyc + 1;
    @(negedge clk);
    miss_valid   = 1'b0;
  endtask

  task automatic drain(input string tag);
    int guard = 0;
    while (q.size() != 0 && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    repeat (14) @(negedge clk);
    chk(q.size() == 0, tag, "pending expected requests", q.size(), 0);
    hit_m.delete();
    dirty_m.delete();
  endtask

  bit done = 1'b0;

  initial begin
    int e;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk(!mem_req_valid && !probe_valid, "R1", "idle outputs after reset",
          int'({probe_valid, mem_req_valid}), 0);
    end

    // fixed count on any miss
    cur_tag = "R3"; cfg_vl_mode = 1'b0; cfg_fixed_k = 4'd3;
    drive_miss('h100, 1'b0, e);
    expect_req(e, 0, 'h100, "R2");
    expect_req(e + 10, 1, 'h101, "R3");
    expect_req(e + 20, 1, 'h102, "R6");
    expect_req(e + 30, 1, 'h103, "R3");
    drain("R3");

    // vector policy: non-sequential miss gets only its demand
    cur_tag = "R4"; cfg_vl_mode = 1'b1; cfg_vl_mult = 4'd1; vec_len = 7'd40;
    drive_miss('h140, 1'b0, e);
    expect_req(e, 0, 'h140, "R4");
    drain("R4");

    // vector policy: 1*40*4 = 160 bytes -> 3 lines
    cur_tag = "R5";
    drive_miss('h140, 1'b1, e);
    expect_req(e, 0, 'h140, "R5");
    for (int i = 1; i <= 3; i++) expect_req(e + 10 * i, 1, 'h140 + i, "R5");
    drain("R5");

    // vector policy saturates at 15 lines
    cfg_vl_mult = 4'd15; vec_len = 7'd127;
    drive_miss('h200, 1'b1, e);
    expect_req(e, 0, 'h200, "R5");
    for (int i = 1; i <= 15; i++) expect_req(e + 10 * i, 1, 'h200 + i, "R5");
    drain("R5");

    // resident line skipped in one cycle
    cur_tag = "R7"; cfg_vl_mode = 1'b0; cfg_fixed_k = 4'd3;
    hit_m['h301] = 1'b1;
    drive_miss('h300, 1'b0, e);
    expect_req(e, 0, 'h300, "R7");
    expect_req(e + 11, 1, 'h302, "R7");
    expect_req(e + 21, 1, 'h303, "R7");
    drain("R7");

    // region boundary at 4 KB (64 lines)
    cur_tag = "R8"; cfg_fixed_k = 4'd4;
    drive_miss('h43E, 1'b0, e);
    expect_req(e, 0, 'h43E, "R8");
    expect_req(e + 10, 1, 'h43F, "R8");
    drain("R8");

    // dirty victim refused without buffer
    cur_tag = "R9"; cfg_fixed_k = 4'd2; cfg_wb_en = 1'b0;
    dirty_m['h501] = 1'b1;
    drive_miss('h500, 1'b0, e);
    expect_req(e, 0, 'h500, "R9");
    expect_req(e + 11, 1, 'h502, "R9");
    drain("R9");

    // dirty victims buffered, then written back oldest first
    cur_tag = "R10"; cfg_wb_en = 1'b1;
    dirty_m['h601] = 1'b1; dirty_m['h602] = 1'b1;
    drive_miss('h600, 1'b0, e);
    expect_req(e, 0, 'h600, "R10");
    expect_req(e + 10, 1, 'h601, "R10");
    expect_req(e + 20, 1, 'h602, "R10");
    expect_req(e + 29, 2, 'h701, "R10");
    expect_req(e + 38, 2, 'h702, "R10");
    drain("R10");

    // buffer full: third dirty victim refused
    cur_tag = "R11"; cfg_fixed_k = 4'd3;
    dirty_m['h801] = 1'b1; dirty_m['h802] = 1'b1; dirty_m['h803] = 1'b1;
    drive_miss('h800, 1'b0, e);
    expect_req(e, 0, 'h800, "R11");
    expect_req(e + 10, 1, 'h801, "R11");
    expect_req(e + 20, 1, 'h802, "R11");
    expect_req(e + 30, 2, 'h901, "R11");
    expect_req(e + 39, 2, 'h902, "R11");
    drain("R11");

    // demand during a burst waits for the fill, older burst dropped
    cur_tag = "R12"; cfg_fixed_k = 4'd4; cfg_wb_en = 1'b0;
    drive_miss('hA00, 1'b0, e);
    expect_req(e, 0, 'hA00, "R12");
    expect_req(e + 10, 1, 'hA01, "R12");
    expect_req(e + 19, 0, 'hB00, "R12");
    for (int i = 1; i <= 4; i++) expect_req(e + 19 + 10 * i, 1, 'hB00 + i, "R12");
    while (cyc < e + 13) @(negedge clk);
    begin
      int e2;
      drive_miss('hB00, 1'b0, e2);
    end
    drain("R12");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL %s watchdog actual=%0d expected=%0d", cur_tag, cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule